// File: doc/BRIEF.md
# Address-Sequence Command Unlock Detector

This block sits beside a byte-wide memory with a 13-bit address. It watches the stream of accesses, one per chip-enable cycle, and looks for a fixed run of six consecutive reads. The first five reads must hit a fixed ladder of addresses. The sixth read picks the command. One final address asks for the array to be saved to nonvolatile storage. The other asks for the nonvolatile copy to be loaded back. When a run completes, the block raises a single-cycle request on the matching output. It then holds a busy level, which the surrounding logic uses to lock out memory access, until the transfer engine reports completion.

Any access that does not match breaks the run and discards all progress. That includes a write, a read of an unexpected address, or a wrong sixth address. A read of the ladder's first address is the one exception: it is taken as a fresh first step. Accesses that arrive while a request is being issued, or while busy is high, are ignored.

Top module: `nvcmd_unlock`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the next state has `storeReq`, `recallReq` and `busy` all low, and the step count at zero. The reset is synchronous and active low.
- R2: An access is one clock cycle with `accStrobe` high, and it is a read when `wrEnN` is high. The first five reads of a run must be at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order. Idle cycles between accesses, with `accStrobe` low, neither advance nor break a run.
- R3: Suppose the five-step prefix has been matched and the next access is a read of 0x0F0F. Then `storeReq` is high for exactly the one cycle after that access's clock edge, and `recallReq` stays low.
- R4: Suppose the five-step prefix has been matched and the next access is a read of 0x0F0E. Then `recallReq` is high for exactly the one cycle after that access's clock edge, and `storeReq` stays low.
- R5: A write access, with `wrEnN` low, at any point of a run aborts it. No request follows, even if the remaining steps are then supplied.
- R6: A read of any address other than the expected next step aborts the run without a request. At the sixth step, that means any address other than 0x0F0F or 0x0F0E.
- R7: When an aborting access is a read of 0x0000, it counts as step one of a new run. Steps two to six that follow it complete the run.
- R8: `busy` goes high in the cycle after a request pulse. It stays high until `xferDone` is sampled high while busy, and it is low from the next cycle on.
- R9: Accesses in the request cycle or while `busy` is high produce no request and do not advance the step count. After busy clears, a run must start again from step one.
- R10: A reset in the middle of a run discards its progress. Supplying the remaining steps after reset produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| accStrobe | input | 1 | One-cycle strobe marking a chip-enable access |
| wrEnN | input | 1 | Write-enable level, low for a write, high for a read |
| accAddr | input | 13 | Address of the access |
| xferDone | input | 1 | Completion indication from the nonvolatile transfer |
| storeReq | output | 1 | One-cycle request to save the array |
| recallReq | output | 1 | One-cycle request to reload the array |
| busy | output | 1 | Transfer in progress, memory access locked out |

## Verification
The checker tests the following on every cycle:
- the two requests are one cycle wide and never high together;
- every request traces back to a read of the matching final address made while the block was idle;
- busy follows each request and holds until completion, then drops;
- no request appears while busy is high.

Whether a request is correct depends on the whole ladder of prior accesses. The bench's scenarios are the only way to show that behaviour. They sweep an abort at every step with a write, a wrong read and a restarting read of 0x0000. They also cover wrong sixth addresses, idle gaps, accesses during busy, and a reset in the middle of a run.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int ADDR_W     = 13;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t STORE_ADDR  = 13'h0F0F;
  localparam addr_t RECALL_ADDR = 13'h0F0E;

  // expected address of prefix step idx (0-based)
  function automatic addr_t prefixAddr(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  // strobes from control to the step counter datapath
  typedef struct packed {
    logic stepInc;
    logic stepOne;
    logic stepClr;
  } stepCtl_t;

  typedef enum logic [1:0] {
    PH_ARM  = 2'd0,
    PH_FIRE = 2'd1,
    PH_BUSY = 2'd2
  } phase_t;
endpackage

// File: rtl/nvcmd_datapath.sv
module nvcmd_datapath
  import nvcmd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  addr_t    accAddr,
  input  stepCtl_t ctl,
  output logic     hitNext,
  output logic     hitFirst,
  output logic     hitStore,
  output logic     hitRecall,
  output logic     atLast
);
  logic [STEP_W-1:0]     stepCnt;
  logic [PREFIX_LEN-1:0] hitVec;

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : gen_cmp
    assign hitVec[g] = (accAddr == prefixAddr(g));
  end

  always_comb begin
    hitNext = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (stepCnt == STEP_W'(i)) hitNext = hitVec[i];
    end
  end

  assign hitFirst  = hitVec[0];
  assign hitStore  = (accAddr == STORE_ADDR);
  assign hitRecall = (accAddr == RECALL_ADDR);
  assign atLast    = (stepCnt == STEP_W'(PREFIX_LEN));

  always_ff @(posedge clk) begin
    if (!rstN)            stepCnt <= '0;
    else if (ctl.stepClr) stepCnt <= '0;
    else if (ctl.stepOne) stepCnt <= STEP_W'(1);
    else if (ctl.stepInc) stepCnt <= stepCnt + STEP_W'(1);
  end
endmodule

// File: rtl/nvcmd_control.sv
module nvcmd_control
  import nvcmd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     accStrobe,
  input  logic     wrEnN,
  input  logic     xferDone,
  input  logic     hitNext,
  input  logic     hitFirst,
  input  logic     hitStore,
  input  logic     hitRecall,
  input  logic     atLast,
  output stepCtl_t ctl,
  output logic     storeReq,
  output logic     recallReq,
  output logic     busy
);
  phase_t phase, phaseNext;
  logic   fire;
  logic   isRead;

  assign isRead = accStrobe && wrEnN;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    fire      = 1'b0;
    case (phase)
      PH_ARM: begin
        if (accStrobe) begin
          if (isRead && !atLast && hitNext) begin
            ctl.stepInc = 1'b1;
          end else if (isRead && atLast && (hitStore || hitRecall)) begin
            fire        = 1'b1;
            ctl.stepClr = 1'b1;
            phaseNext   = PH_FIRE;
          end else if (isRead && hitFirst) begin
            ctl.stepOne = 1'b1;
          end else begin
            ctl.stepClr = 1'b1;
          end
        end
      end
      PH_FIRE: phaseNext = PH_BUSY;
      PH_BUSY: if (xferDone) phaseNext = PH_ARM;
      default: phaseNext = PH_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_ARM;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      phase     <= phaseNext;
      storeReq  <= fire && hitStore;
      recallReq <= fire && hitRecall;
    end
  end

  assign busy = (phase == PH_BUSY);
endmodule

// File: rtl/nvcmd_unlock.sv
module nvcmd_unlock
  import nvcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStrobe,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              xferDone,
  output logic              storeReq,
  output logic              recallReq,
  output logic              busy
);
  stepCtl_t ctl;
  logic     hitNext, hitFirst, hitStore, hitRecall, atLast;

  nvcmd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .accAddr   (accAddr),
    .ctl       (ctl),
    .hitNext   (hitNext),
    .hitFirst  (hitFirst),
    .hitStore  (hitStore),
    .hitRecall (hitRecall),
    .atLast    (atLast)
  );

  nvcmd_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .accStrobe (accStrobe),
    .wrEnN     (wrEnN),
    .xferDone  (xferDone),
    .hitNext   (hitNext),
    .hitFirst  (hitFirst),
    .hitStore  (hitStore),
    .hitRecall (hitRecall),
    .atLast    (atLast),
    .ctl       (ctl),
    .storeReq  (storeReq),
    .recallReq (recallReq),
    .busy      (busy)
  );
endmodule

// File: rtl/nvcmd_unlock_chk.sv
module nvcmd_unlock_chk
  import nvcmd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accStrobe,
  input logic              wrEnN,
  input logic [ADDR_W-1:0] accAddr,
  input logic              xferDone,
  input logic              storeReq,
  input logic              recallReq,
  input logic              busy
);
  a_r3_store_source: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(accStrobe && wrEnN && accAddr == STORE_ADDR && !busy && !storeReq && !recallReq));

  a_r4_recall_source: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> $past(accStrobe && wrEnN && accAddr == RECALL_ADDR && !busy && !storeReq && !recallReq));

  a_r3_store_single: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  a_r4_recall_single: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  a_r8_busy_follows: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |=> busy);

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone) |=> busy);

  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferDone) |=> !busy);

  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(storeReq || recallReq));

  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!storeReq && !recallReq));
endmodule

bind nvcmd_unlock nvcmd_unlock_chk u_chk (.*);

// File: tb/nvcmd_unlock_bench.sv
module nvcmd_unlock_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accStrobe = 1'b0;
  logic        wrEnN = 1'b1;
  logic [12:0] accAddr = '0;
  logic        xferDone = 1'b0;
  logic        storeReq, recallReq, busy;
  logic        sampS, sampR;
  int          nChecks = 0;
  int          nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvcmd_unlock u_nvcmd_unlock (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .wrEnN(wrEnN),
    .accAddr(accAddr), .xferDone(xferDone),
    .storeReq(storeReq), .recallReq(recallReq), .busy(busy)
  );

  function automatic logic [12:0] stepAddr(input int i, input bit toStore);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      4: return 13'h10F0;
      default: return toStore ? 13'h0F0F : 13'h0F0E;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one access; pulses sampled in the cycle after its edge
  task automatic access(input logic [12:0] a, input logic rd);
    @(negedge clk);
    accStrobe = 1'b1; accAddr = a; wrEnN = rd;
    @(negedge clk);
    accStrobe = 1'b0; wrEnN = 1'b1;
    sampS = storeReq; sampR = recallReq;
  endtask

  task automatic accessQuiet(input string req, input logic [12:0] a, input logic rd);
    access(a, rd);
    chk(req, {2'b0, sampS, sampR}, 4'b0000);
  endtask

  // steps from..5 of a run, final one checked for the pulse
  task automatic runSteps(input string req, input int from, input bit toStore,
                          input bit expFire, input int gap);
    for (int i = from; i < 6; i++) begin
      repeat (gap) @(negedge clk);
      access(stepAddr(i, toStore), 1'b1);
      if (i == 5 && expFire)
        chk(req, {2'b0, sampS, sampR}, toStore ? 4'b0010 : 4'b0001);
      else
        chk(req, {2'b0, sampS, sampR}, 4'b0000);
    end
  endtask

  // after a checked pulse: busy behaviour and completion
  task automatic finishXfer(input string req);
    @(negedge clk);
    chk("R8 busy after pulse", {1'b0, busy, storeReq, recallReq}, 4'b0100);
    repeat (3) @(negedge clk);
    chk("R8 busy holds", {3'b0, busy}, 4'b0001);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    chk(req, {3'b0, busy}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {1'b0, busy, storeReq, recallReq}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {1'b0, busy, storeReq, recallReq}, 4'b0000);

    // R3 / R4 / R2 with idle gaps
    for (int gap = 0; gap < 3; gap++) begin
      runSteps("R3 store run", 0, 1'b1, 1'b1, gap);
      finishXfer("R8 busy clears store");
      runSteps("R4 recall run", 0, 1'b0, 1'b1, gap);
      finishXfer("R8 busy clears recall");
    end

    // abort sweep: position p, kind 0 write, 1 wrong read, 2 read of 0x0000
    for (int p = 0; p < 6; p++) begin
      for (int kind = 0; kind < 3; kind++) begin
        if (!(kind == 2 && p == 0)) begin
          for (int i = 0; i < p; i++)
            accessQuiet("R2 prefix step", stepAddr(i, 1'b1), 1'b1);
          if (kind == 0) begin
            accessQuiet("R5 write abort", stepAddr(p, 1'b1), 1'b0);
            runSteps("R5 no request after write", p + 1, 1'b1, 1'b0, 0);
          end else if (kind == 1) begin
            accessQuiet("R6 wrong read abort", stepAddr(p, 1'b1) ^ 13'h0100, 1'b1);
            runSteps("R6 no request after wrong read", p + 1, 1'b1, 1'b0, 0);
          end else begin
            accessQuiet("R7 restart read", 13'h0000, 1'b1);
            runSteps("R7 restarted run fires", 1, (p % 2) == 0, 1'b1, 0);
            finishXfer("R8 busy clears after restart");
          end
        end
      end
    end

    // R6 wrong sixth addresses
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 5; i++)
        accessQuiet("R2 prefix step", stepAddr(i, 1'b1), 1'b1);
      accessQuiet("R6 bad sixth", (d == 0) ? 13'h0F0C : (d == 1) ? 13'h0F0D :
                  (d == 2) ? 13'h1F0F : 13'h0F1E, 1'b1);
    end
    runSteps("R6 clean after bad sixth", 0, 1'b1, 1'b1, 0);

    // R9: accesses in the request cycle and while busy are ignored
    @(negedge clk);
    chk("R9 busy set", {3'b0, busy}, 4'b0001);
    for (int i = 0; i < 6; i++)
      accessQuiet("R9 ignored while busy", stepAddr(i, 1'b0), 1'b1);
    accessQuiet("R9 write ignored while busy", 13'h0000, 1'b0);
    chk("R9 still busy", {3'b0, busy}, 4'b0001);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    chk("R8 busy cleared", {3'b0, busy}, 4'b0000);
    runSteps("R9 no carried progress", 1, 1'b0, 1'b0, 0);
    runSteps("R9 fresh run fires", 0, 1'b0, 1'b1, 0);
    finishXfer("R8 busy clears");

    // R10 reset mid-run
    for (int i = 0; i < 3; i++)
      accessQuiet("R2 prefix step", stepAddr(i, 1'b1), 1'b1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 mid-run reset outputs", {1'b0, busy, storeReq, recallReq}, 4'b0000);
    runSteps("R10 progress discarded", 3, 1'b1, 1'b0, 0);
    runSteps("R10 full run after reset", 0, 1'b1, 1'b1, 0);
    finishXfer("R8 busy clears final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule